// File: doc/BRIEF.md
# Byte-Lane Command/Response Data Window

This block is the host-facing data window of a command/response port. The host sends a command as a stream of bytes and later reads the response back through the same small window. Each host access carries 1, 2 or 4 bytes. The window sits at one legacy word and at a 16-word extended range, and an access never crosses a 32-bit word. Writes are unpacked into consecutive bytes of a command buffer. Reads are packed from a response buffer. Both directions use little-endian lane order.

While a command is arriving, the block keeps the write offset and compares it against two limits: the buffer depth and the length field in the command header. From that comparison it reports to the surrounding status controller whether more bytes are expected or the command is complete. The status state machine and the command execution are outside this block. The block receives the port state and the active locality as plain inputs. Responses arrive on a byte stream from the execution side.

The host access channel is valid/ready. An access is taken on a cycle where both `acc_valid` and `acc_ready` are high. `acc_ready` drops for every cycle in which a response byte is offered on `rsp_valid`, so response loading always has priority over host access. The response stream never back-pressures: `rsp_ready` is always high. A read that is accepted returns its data on `rd_data`, flagged by a one-cycle `rd_valid`, on the cycle after acceptance.

Top module: `dfifo_port`

## Requirements
- R1: An access hits the window only when its word address (`acc_addr` with the low two bits cleared) is 0x024 or lies in the range 0x080 to 0x0BC. A write anywhere else stores nothing. A read anywhere else returns 32'hFFFFFFFF.
- R2: The number of bytes an access moves is the smaller of `acc_size` (capped at 4) and 4 minus `acc_addr[1:0]`.
- R3: Written bytes come from `acc_wdata` starting at lane 0 (bits 7:0), and go to consecutive command-buffer offsets from the current write offset. `rx_count` gives the new offset, and `cmd_rd_addr`/`cmd_rd_data` reads the stored bytes back.
- R4: A read is answered one cycle after acceptance, with `rd_valid` high for one cycle. The first byte sits in bits 7:0, and lanes beyond the effective size read zero.
- R5: A read taken while `port_state` is not COMPLETION (4) returns 8'hFF in each effective lane. A read from a locality other than `active_loc` returns 32'hFFFFFFFF and consumes no response byte.
- R6: A write is dropped, leaving `rx_count` unchanged, when any one of these holds: `acc_loc` differs from `active_loc`; `port_state` is EXECUTION (3) or COMPLETION (4); or no more bytes are expected.
- R7: A window write while `port_state` is READY (1) starts a new command. The offset restarts at 0, `exp_more` is set and `sts_valid` is cleared before the bytes are stored.
- R8: Once at least 6 bytes are held, the command length is the big-endian 32-bit value in header bytes 2 (most significant) to 5. `exp_more` stays high while that length exceeds `rx_count`. When it does not, `exp_more` clears and `cmd_done` pulses for one cycle.
- R9: A write whose bytes would pass DEPTH stores only up to DEPTH. It then clears `exp_more` and sets `sts_valid` without `cmd_done`. Filling the buffer exactly keeps `exp_more` set.
- R10: `valid_irq` pulses for one cycle when the length check runs while `sts_valid` was clear, which happens once per command.
- R11: A response beat that arrives after a beat marked `rsp_last` (or after reset) starts a new response at index 0 and rewinds the read position. In COMPLETION, reads consume response bytes in order. Lanes past the response length read 8'hFF, and `rsp_drained` pulses on the read that takes the final byte.
- R12: `acc_ready` is low in every cycle in which `rsp_valid` is high, and `rsp_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access offered |
| acc_ready | output | 1 | Host access can be taken |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset within the locality frame |
| acc_size | input | 3 | Requested byte count (1, 2 or 4) |
| acc_wdata | input | 32 | Write data, first byte in bits 7:0 |
| acc_loc | input | LOC_W | Locality issuing the access |
| rd_valid | output | 1 | Read data valid (one cycle) |
| rd_data | output | 32 | Packed read data |
| active_loc | input | LOC_W | Locality that currently owns the port |
| port_state | input | 3 | 0 idle, 1 ready, 2 reception, 3 execution, 4 completion |
| rsp_valid | input | 1 | Response byte offered |
| rsp_ready | output | 1 | Response byte accepted (always 1) |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Final byte of the response |
| cmd_rd_addr | input | $clog2(DEPTH) | Command buffer read index |
| cmd_rd_data | output | 8 | Command buffer byte at that index |
| rx_count | output | $clog2(DEPTH+1) | Bytes of the current command held |
| exp_more | output | 1 | More command bytes are expected |
| sts_valid | output | 1 | Length status has been evaluated |
| cmd_done | output | 1 | One-cycle pulse: command complete |
| valid_irq | output | 1 | One-cycle pulse: status became valid |
| rsp_drained | output | 1 | One-cycle pulse: last response byte read |

## Verification
The window decode is swept over every word of both windows and the four words just outside them. At each word the sweep tries every start lane with sizes 1 to 4. This separates clipping faults, lane-order faults and off-by-one window bounds. Three command sequences probe the length check: one with the length above 6, one below 6, and one that reaches 6 bytes only on a later single-byte write. Together they show whether the check waits for six bytes and reads the field big-endian. Filling the buffer exactly is compared with overrunning it by a clipped multi-byte write. Reads sweep every lane/size pair across and past a loaded response. Locality and state mismatches are placed mid-stream, which shows that they consume nothing.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  localparam int LANES      = 4;
  localparam int HDR_POS    = 2;
  localparam int HDR_BYTES  = 4;
  localparam int HDR_END    = HDR_POS + HDR_BYTES;
  localparam logic [7:0] NO_DATA = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_DONE  = 3'd4
  } port_state_e;
endpackage

// File: rtl/dfifo_win_decode.sv
module dfifo_win_decode #(
  parameter int ADDR_W     = 12,
  parameter int LEGACY_OFF = 'h024,
  parameter int XWIN_LO    = 'h080,
  parameter int XWIN_HI    = 'h0BC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic              hit,
  output logic [2:0]        nbytes
);
  logic [ADDR_W-1:0] word_base;
  logic [2:0]        room;
  logic [2:0]        req;

  // word-aligned base of the access
  assign word_base = {addr[ADDR_W-1:2], 2'b00};
  assign hit = (word_base == ADDR_W'(LEGACY_OFF)) ||
               ((word_base >= ADDR_W'(XWIN_LO)) && (word_base <= ADDR_W'(XWIN_HI)));

  // bytes left in the word from the start lane
  assign room   = 3'd4 - {1'b0, addr[1:0]};
  assign req    = (size > 3'd4) ? 3'd4 : size;
  assign nbytes = !hit ? 3'd0 : ((req < room) ? req : room);
endmodule

// File: rtl/dfifo_wr_path.sv
module dfifo_wr_path
  import dfifo_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_fire,
  input  logic                       start,
  input  logic [2:0]                 nbytes,
  input  logic [31:0]                wdata,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [7:0]                 rd_byte,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       exp_o,
  output logic                       valid_o,
  output logic                       done_o,
  output logic                       irq_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OFF_W = $clog2(DEPTH+1);
  localparam int POS_W = $clog2(DEPTH+LANES);

  logic [7:0]                    mem [DEPTH];
  logic [OFF_W-1:0]              off_q;
  logic                          exp_q, valid_q, done_q, irq_q;
  logic [HDR_BYTES-1:0][7:0]     hdr_q;

  logic [OFF_W-1:0]              base_off, new_off;
  logic                          exp_in, valid_in;
  logic [HDR_BYTES-1:0][7:0]     hdr_base, hdr_nxt;
  logic [LANES-1:0]              lane_act, lane_st;
  logic [POS_W-1:0]              pos [LANES];
  logic [7:0]                    lane_byte [LANES];
  logic [2:0]                    n_st;
  logic                          overflow, check, complete;
  logic [31:0]                   cmd_len;

  // a new command restarts offset, header and status
  assign base_off = start ? '0 : off_q;
  assign exp_in   = start | exp_q;
  assign valid_in = start ? 1'b0 : valid_q;
  assign hdr_base = start ? '0 : hdr_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign pos[k]       = POS_W'(base_off) + POS_W'(k);
    assign lane_byte[k] = wdata[8*k +: 8];
    assign lane_act[k]  = wr_fire && exp_in && (3'(k) < nbytes);
    assign lane_st[k]   = lane_act[k] && (pos[k] < POS_W'(DEPTH));
  end

  always_comb begin
    n_st    = '0;
    hdr_nxt = hdr_base;
    for (int k = 0; k < LANES; k++) begin
      n_st = n_st + 3'(lane_st[k]);
      for (int h = 0; h < HDR_BYTES; h++) begin
        if (lane_st[k] && (pos[k] == POS_W'(HDR_POS + h))) hdr_nxt[h] = lane_byte[k];
      end
    end
  end

  assign overflow = |(lane_act & ~lane_st);
  assign new_off  = base_off + OFF_W'(n_st);
  // header byte at offset HDR_POS is the most significant
  assign cmd_len  = {hdr_nxt[0], hdr_nxt[1], hdr_nxt[2], hdr_nxt[3]};
  assign check    = wr_fire && exp_in && !overflow && (new_off >= OFF_W'(HDR_END));
  assign complete = check && (cmd_len <= 32'(new_off));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q   <= '0;
      exp_q   <= 1'b0;
      valid_q <= 1'b0;
      hdr_q   <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      done_q <= complete;
      irq_q  <= check && !valid_in;
      if (wr_fire && exp_in) begin
        off_q   <= new_off;
        hdr_q   <= hdr_nxt;
        valid_q <= valid_in | check | overflow;
        exp_q   <= !(overflow || complete);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (lane_st[k]) mem[pos[k][IDX_W-1:0]] <= lane_byte[k];
    end
  end

  assign rd_byte = mem[rd_addr];
  assign count   = off_q;
  assign exp_o   = exp_q;
  assign valid_o = valid_q;
  assign done_o  = done_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/dfifo_rd_path.sv
module dfifo_rd_path
  import dfifo_pkg::*;
#(
  parameter int RDEPTH = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_valid,
  input  logic [7:0]  ld_data,
  input  logic        ld_last,
  input  logic        take,
  input  logic [2:0]  nbytes,
  output logic [31:0] word,
  output logic        drained_o
);
  localparam int RIDX_W = $clog2(RDEPTH);
  localparam int RLEN_W = $clog2(RDEPTH+1);
  localparam int RPOS_W = $clog2(RDEPTH+LANES);

  logic [7:0]        rmem [RDEPTH];
  logic [RLEN_W-1:0] rlen_q, roff_q;
  logic              loading_q, drained_q;

  logic [LANES-1:0]  avail;
  logic [RPOS_W-1:0] rpos [LANES];
  logic [2:0]        ncons;
  logic [RLEN_W-1:0] roff_nxt;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign rpos[k]  = RPOS_W'(roff_q) + RPOS_W'(k);
    assign avail[k] = (3'(k) < nbytes) && (rpos[k] < RPOS_W'(rlen_q));
    assign word[8*k +: 8] = (3'(k) >= nbytes) ? 8'h00 :
                            avail[k] ? rmem[rpos[k][RIDX_W-1:0]] : NO_DATA;
  end

  always_comb begin
    ncons = '0;
    for (int k = 0; k < LANES; k++) ncons = ncons + 3'(avail[k]);
  end
  assign roff_nxt = roff_q + RLEN_W'(ncons);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rlen_q    <= '0;
      roff_q    <= '0;
      loading_q <= 1'b0;
      drained_q <= 1'b0;
    end else begin
      drained_q <= 1'b0;
      if (ld_valid) begin
        loading_q <= !ld_last;
        if (!loading_q) begin
          rlen_q <= RLEN_W'(1);
          roff_q <= '0;
        end else if (rlen_q < RLEN_W'(RDEPTH)) begin
          rlen_q <= rlen_q + 1'b1;
        end
      end else if (take) begin
        roff_q    <= roff_nxt;
        drained_q <= (ncons != 3'd0) && (roff_nxt == rlen_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_valid) begin
      if (!loading_q) rmem[0] <= ld_data;
      else if (rlen_q < RLEN_W'(RDEPTH)) rmem[rlen_q[RIDX_W-1:0]] <= ld_data;
    end
  end

  assign drained_o = drained_q;
endmodule

// File: rtl/dfifo_port.sv
module dfifo_port
  import dfifo_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LOC_W  = 3,
  parameter int DEPTH  = 1024,
  parameter int RDEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  output logic                       acc_ready,
  input  logic                       acc_write,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic [2:0]                 acc_size,
  input  logic [31:0]                acc_wdata,
  input  logic [LOC_W-1:0]           acc_loc,
  output logic                       rd_valid,
  output logic [31:0]                rd_data,
  input  logic [LOC_W-1:0]           active_loc,
  input  logic [2:0]                 port_state,
  input  logic                       rsp_valid,
  output logic                       rsp_ready,
  input  logic [7:0]                 rsp_data,
  input  logic                       rsp_last,
  input  logic [$clog2(DEPTH)-1:0]   cmd_rd_addr,
  output logic [7:0]                 cmd_rd_data,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                       exp_more,
  output logic                       sts_valid,
  output logic                       cmd_done,
  output logic                       valid_irq,
  output logic                       rsp_drained
);
  logic        hit, loc_ok, st_busy, st_done;
  logic [2:0]  nbytes;
  logic        acc_fire, wr_fire, rd_fire, start, take;
  logic [31:0] rp_word, rd_word;
  logic        rd_valid_q;
  logic [31:0] rd_data_q;

  dfifo_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (acc_addr),
    .size   (acc_size),
    .hit    (hit),
    .nbytes (nbytes)
  );

  // response loading wins over host access
  assign acc_ready = !rsp_valid;
  assign rsp_ready = 1'b1;

  assign loc_ok   = (acc_loc == active_loc);
  assign st_done  = (port_state == ST_DONE);
  assign st_busy  = (port_state == ST_EXEC) || st_done;
  assign acc_fire = acc_valid && acc_ready;
  assign wr_fire  = acc_fire && acc_write && hit && loc_ok && !st_busy && (nbytes != 3'd0);
  assign start    = wr_fire && (port_state == ST_READY);
  assign rd_fire  = acc_fire && !acc_write;
  assign take     = rd_fire && hit && loc_ok && st_done;

  dfifo_wr_path #(.DEPTH(DEPTH)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .start   (start),
    .nbytes  (nbytes),
    .wdata   (acc_wdata),
    .rd_addr (cmd_rd_addr),
    .rd_byte (cmd_rd_data),
    .count   (rx_count),
    .exp_o   (exp_more),
    .valid_o (sts_valid),
    .done_o  (cmd_done),
    .irq_o   (valid_irq)
  );

  dfifo_rd_path #(.RDEPTH(RDEPTH)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (rsp_valid),
    .ld_data   (rsp_data),
    .ld_last   (rsp_last),
    .take      (take),
    .nbytes    (nbytes),
    .word      (rp_word),
    .drained_o (rsp_drained)
  );

  always_comb begin
    rd_word = '1;
    if (hit && loc_ok) begin
      if (st_done) begin
        rd_word = rp_word;
      end else begin
        rd_word = '0;
        for (int k = 0; k < LANES; k++) begin
          if (3'(k) < nbytes) rd_word[8*k +: 8] = NO_DATA;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_fire;
      if (rd_fire) rd_data_q <= rd_word;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/dfifo_port_chk.sv
module dfifo_port_chk #(
  parameter int DEPTH = 1024
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       acc_valid,
  input logic                       acc_ready,
  input logic                       acc_write,
  input logic [2:0]                 port_state,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic                       rd_valid,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic                       exp_more,
  input logic                       sts_valid,
  input logic                       cmd_done,
  input logic                       valid_irq
);
  assert_backpressure_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!acc_ready && rsp_ready));

  assert_read_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !acc_write) |=> rd_valid);

  assert_read_only_when_asked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && acc_ready && !acc_write));

  assert_done_ends_expect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> (!exp_more && sts_valid));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_count) <= 32'(DEPTH));

  assert_irq_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_irq |-> sts_valid);

  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_write && (port_state == 3'd3 || port_state == 3'd4))
      |=> $stable(rx_count));
endmodule

bind dfifo_port dfifo_port_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/dfifo_port_bench.sv
module dfifo_port_bench;
  localparam int DEPTH  = 16;
  localparam int RDEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic        acc_ready;
  logic [11:0] acc_addr;
  logic [2:0]  acc_size;
  logic [31:0] acc_wdata;
  logic [2:0]  acc_loc, active_loc, port_state;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rsp_valid, rsp_ready, rsp_last;
  logic [7:0]  rsp_data;
  logic [3:0]  cmd_rd_addr;
  logic [7:0]  cmd_rd_data;
  logic [4:0]  rx_count;
  logic        exp_more, sts_valid, cmd_done, valid_irq, rsp_drained;

  always #5 clk = ~clk;

  dfifo_port #(.ADDR_W(12), .LOC_W(3), .DEPTH(DEPTH), .RDEPTH(RDEPTH)) u_dfifo_port (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .acc_loc(acc_loc), .rd_valid(rd_valid), .rd_data(rd_data),
    .active_loc(active_loc), .port_state(port_state), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .cmd_rd_addr(cmd_rd_addr), .cmd_rd_data(cmd_rd_data), .rx_count(rx_count),
    .exp_more(exp_more), .sts_valid(sts_valid), .cmd_done(cmd_done),
    .valid_irq(valid_irq), .rsp_drained(rsp_drained)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic        got_done, got_irq, got_rdv, got_drain;
  logic [31:0] got_rd;
  logic [7:0]  rm [RDEPTH];
  int          rlen = 0;
  int          roff = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic access(input bit wr, input int addr, input int size, input logic [31:0] data, input int loc);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = 12'(addr);
    acc_size = 3'(size); acc_wdata = data; acc_loc = 3'(loc);
    @(negedge clk);
    acc_valid = 1'b0;
    got_done = cmd_done; got_irq = valid_irq; got_rdv = rd_valid;
    got_rd = rd_data; got_drain = rsp_drained;
  endtask

  task automatic chk_byte(input string tag, input int idx, input logic [7:0] exp);
    cmd_rd_addr = 4'(idx);
    #1;
    chk(tag, {24'h0, cmd_rd_data}, {24'h0, exp});
  endtask

  task automatic chk_flags(input string tag, input int cnt, input bit ex, input bit vl, input bit dn, input bit iq);
    chk({tag, " count"}, 32'(rx_count), 32'(cnt));
    chk({tag, " exp_more"}, 32'(exp_more), 32'(ex));
    chk({tag, " sts_valid"}, 32'(sts_valid), 32'(vl));
    chk({tag, " cmd_done"}, 32'(got_done), 32'(dn));
    chk({tag, " valid_irq"}, 32'(got_irq), 32'(iq));
  endtask

  task automatic load_rsp(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = 8'(seed + i); rsp_last = (i == n - 1);
      #1;
      // R12: host channel held off while a response byte is offered
      chk("R12 acc_ready low", 32'(acc_ready), 32'd0);
      chk("R12 rsp_ready high", 32'(rsp_ready), 32'd1);
      rm[i] = 8'(seed + i);
    end
    @(negedge clk);
    rsp_valid = 1'b0; rsp_last = 1'b0;
    rlen = min2(n, RDEPTH);
    roff = 0;
  endtask

  task automatic model_read(input int lo, input int sz, output logic [31:0] w, output bit drain);
    int n, cnt;
    n = min2(min2(sz, 4), 4 - lo);
    w = '0; cnt = 0;
    for (int k = 0; k < n; k++) begin
      if (roff + k < rlen) begin w[8*k +: 8] = rm[roff + k]; cnt++; end
      else w[8*k +: 8] = 8'hFF;
    end
    drain = (cnt > 0) && (roff + cnt == rlen);
    roff += cnt;
  endtask

  function automatic logic [7:0] pat(input int wi, input int lo, input int sz, input int k);
    return 8'(wi * 13 + lo * 5 + sz * 3 + k * 41 + 1);
  endfunction

  function automatic int word_addr(input int wi);
    if (wi == 0) return 'h24;
    if (wi <= 16) return 'h80 + 4 * (wi - 1);
    case (wi)
      17: return 'h20;
      18: return 'h28;
      19: return 'h7C;
      default: return 'hC0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int mcnt;
    bit mexp;
    logic [31:0] d, ew;
    bit edrain;

    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_size = '0;
    acc_wdata = '0; acc_loc = '0; active_loc = '0; port_state = 3'd0;
    rsp_valid = 1'b0; rsp_data = '0; rsp_last = 1'b0; cmd_rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset count", 32'(rx_count), 0);
    chk("reset exp_more", 32'(exp_more), 0);
    chk("reset sts_valid", 32'(sts_valid), 0);
    chk("reset rd_valid", 32'(rd_valid), 0);
    chk("reset acc_ready R12", 32'(acc_ready), 1);

    // R1 R2 R3 R7: decode and lane sweep, each in-window write starts a command
    port_state = 3'd1;
    mcnt = 0; mexp = 0;
    for (int wi = 0; wi <= 20; wi++) begin
      for (int lo = 0; lo < 4; lo++) begin
        for (int sz = 1; sz <= 4; sz++) begin
          int n;
          bit inwin;
          inwin = (wi <= 16);
          for (int k = 0; k < 4; k++) d[8*k +: 8] = pat(wi, lo, sz, k);
          access(1'b1, word_addr(wi) + lo, sz, d, 0);
          n = inwin ? min2(sz, 4 - lo) : 0;
          if (inwin) begin mcnt = n; mexp = 1; end
          chk(inwin ? "R2 clipped count" : "R1 outside window count", 32'(rx_count), 32'(mcnt));
          chk("R7 exp_more after start", 32'(exp_more), 32'(mexp));
          if (inwin) begin
            for (int k = 0; k < n; k++) chk_byte("R3 lane order", k, pat(wi, lo, sz, k));
          end
        end
      end
    end

    // R8 R10: length 10, crossing the threshold on a clipped write
    port_state = 3'd1;
    access(1'b1, 'h24, 4, 32'h0000_0180, 0);
    chk_flags("R7 start", 4, 1, 0, 0, 0);
    port_state = 3'd2;
    access(1'b1, 'h86, 4, 32'hEEEE_0A00, 0);
    chk_flags("R8 length 10 at 6", 6, 1, 1, 0, 1);
    chk_byte("R2 clipped upper lanes", 5, 8'h0A);
    access(1'b1, 'hBC, 4, 32'h4433_2211, 0);
    chk_flags("R8 complete at 10", 10, 0, 1, 1, 0);
    chk_byte("R3 tail byte", 9, 8'h44);
    access(1'b1, 'h24, 4, 32'h5555_5555, 0);
    chk_flags("R6 no expect drop", 10, 0, 1, 0, 0);

    // R8: length below six completes at six
    port_state = 3'd1;
    access(1'b1, 'h24, 2, 32'h0000_BBAA, 0);
    chk_flags("R7 restart", 2, 1, 0, 0, 0);
    port_state = 3'd2;
    access(1'b1, 'h24, 4, 32'h0300_0000, 0);
    chk_flags("R8 length 3", 6, 0, 1, 1, 1);

    // R8 R10: length 7, check waits for six bytes
    port_state = 3'd1;
    access(1'b1, 'h24, 4, 32'h0000_0000, 0);
    port_state = 3'd2;
    access(1'b1, 'h24, 1, 32'h0000_0000, 0);
    chk_flags("R8 five bytes no check", 5, 1, 0, 0, 0);
    access(1'b1, 'h24, 1, 32'h0000_0007, 0);
    chk_flags("R10 first check", 6, 1, 1, 0, 1);
    access(1'b1, 'h24, 1, 32'h0000_0099, 0);
    chk_flags("R8 complete at 7", 7, 0, 1, 1, 0);

    // R9: overrun by a multi-byte write
    port_state = 3'd1;
    access(1'b1, 'h24, 4, 32'h0, 0);
    port_state = 3'd2;
    access(1'b1, 'h24, 2, 32'h0000_0001, 0);
    chk_flags("R10 length 256", 6, 1, 1, 0, 1);
    access(1'b1, 'h24, 4, 32'h0, 0);
    access(1'b1, 'h24, 4, 32'h0, 0);
    access(1'b1, 'h24, 4, 32'hDDCC_BBAA, 0);
    chk_flags("R9 overrun", 16, 0, 1, 0, 0);
    chk_byte("R9 stored up to depth", 14, 8'hAA);
    chk_byte("R9 last stored", 15, 8'hBB);

    // R9: exact fill keeps expecting
    port_state = 3'd1;
    access(1'b1, 'h24, 4, 32'h0, 0);
    port_state = 3'd2;
    access(1'b1, 'h24, 2, 32'h0000_0001, 0);
    access(1'b1, 'h24, 4, 32'h0, 0);
    access(1'b1, 'h24, 4, 32'h0, 0);
    access(1'b1, 'h24, 2, 32'h0, 0);
    chk_flags("R9 exact fill", 16, 1, 1, 0, 0);
    access(1'b1, 'h24, 1, 32'h0, 0);
    chk_flags("R9 one past", 16, 0, 1, 0, 0);

    // R6: drops by locality and state
    port_state = 3'd1;
    access(1'b1, 'h24, 4, 32'h0, 0);
    port_state = 3'd2;
    access(1'b1, 'h24, 4, 32'h0, 1);
    chk("R6 foreign locality", 32'(rx_count), 4);
    port_state = 3'd3;
    access(1'b1, 'h24, 4, 32'h0, 0);
    chk("R6 execution", 32'(rx_count), 4);
    port_state = 3'd4;
    access(1'b1, 'h24, 4, 32'h0, 0);
    chk("R6 completion", 32'(rx_count), 4);
    chk("R6 still expecting", 32'(exp_more), 1);

    // R4 R5 R11: read sweep across and past an 11-byte response
    port_state = 3'd4;
    load_rsp(11, 'h30);
    for (int lo = 0; lo < 4; lo++) begin
      for (int sz = 1; sz <= 4; sz++) begin
        if (lo == 2 && sz == 2) begin
          access(1'b0, 'h24, 4, 32'h0, 3);
          chk("R5 foreign locality read", got_rd, 32'hFFFF_FFFF);
          access(1'b0, 'h28, 4, 32'h0, 0);
          chk("R1 outside window read", got_rd, 32'hFFFF_FFFF);
        end
        model_read(lo, sz, ew, edrain);
        access(1'b0, 'h80 + 4 * sz + lo, sz, 32'h0, 0);
        chk("R4 rd_valid", 32'(got_rdv), 1);
        chk("R4 R11 packed read", got_rd, ew);
        chk("R11 drained pulse", 32'(got_drain), 32'(edrain));
      end
    end

    port_state = 3'd2;
    access(1'b0, 'h25, 4, 32'h0, 0);
    chk("R5 no-data lanes", got_rd, 32'h00FF_FFFF);

    // R11: a new response rewinds
    load_rsp(3, 'h70);
    port_state = 3'd4;
    access(1'b0, 'h24, 4, 32'h0, 0);
    chk("R11 restart read", got_rd, 32'hFF72_7170);
    chk("R11 restart drained", 32'(got_drain), 1);

    @(negedge clk);
    chk("R4 rd_valid idle", 32'(rd_valid), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule